// File: doc/BRIEF.md
# Per-pin GPIO register bank

This block controls a bank of general-purpose pads. Each pad has its own byte-wide control register on a simple memory-mapped bus. Reading a register returns the pad's synchronized input level, the output value currently held for it, and its active-low output enable. Writing a register sets the held output value and the enable for that pad only.

The registers are spaced one word apart. They are arranged in five pin groups, and the groups sit at separate base offsets with unused gaps between them. Pads are numbered in ascending address order, and that number is their index on the pad vectors.

The last group of four pins is also forwarded, after synchronization, as level signals to fixed line numbers of a parent interrupt controller. That controller does all type selection, masking and acknowledgement. The output and enable bits read back from a register are sufficient to restore the pin's state, by writing them back after the state has been lost through a reset.

Top module: `pinbank_gpio`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every pin is an input (pad_oe_n bit = 1) with output value 0, parent_irq is all zero and bus_rdata is zero.
- R2: A write to a mapped pin register takes effect at the clock edge that samples it: bit 4 of the data goes to that pad's pad_out bit and bit 5 goes to its pad_oe_n bit (1 = input, 0 = drive pad_out).
- R3: A read returns its data in the cycle after the request: bit 0 = synchronized pad level, bit 4 = output value, bit 5 = output enable (active low), all other bits 0; in cycles without a read in the previous cycle bus_rdata is 0.
- R4: A pad level passes through a two-flop synchronizer before it is reported in bit 0 or forwarded to a parent line, so a change becomes visible two clock edges after it is presented.
- R5: Registers sit at byte offsets base + 4*k for these groups: 0x50 (4 pins), 0x88 (16 pins), 0x140 (6 pins), 0x188 (2 pins), 0x1C0 (4 pins). Pins are indexed 0 to 31 in that order.
- R6: An access to an offset that is not a mapped register, including a non-word-aligned offset, reads as zero and changes no pin.
- R7: A write changes at most the addressed pin. Without a write, pad_out and pad_oe_n hold their values.
- R8: The pin at offset X in the 0x1C0 group drives parent line (X - 0x1C0)/4 + 28, so lines 28 to 31 follow pins 28 to 31. Lines 0 to 27 stay 0.
- R9: Bit 0 and bits 1 to 3, 6 and 7 of write data are ignored. Writing back bits 4 and 5 of a pin's read value after a reset restores that pin's pad_out and pad_oe_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 9 | Byte offset of the access |
| bus_wr | input | 1 | Write request, single cycle |
| bus_rd | input | 1 | Read request, data one cycle later |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 32 | Asynchronous pad input levels, by pin index |
| pad_out | output | 32 | Output value per pin |
| pad_oe_n | output | 32 | Active-low output enable per pin |
| parent_irq | output | 32 | Level lines to the parent interrupt controller |

## Verification
The assertions assume that bus_rd and bus_wr are never raised in the same cycle. They also assume that pad_in is sampled on the same clock as the bench and is never changed at an active edge. The stimulus keeps to this: it drives every bus request and every pad change on a falling edge, and it issues one access at a time. The sweeps visit every byte offset of the 9-bit address space for reads and for writes to unmapped offsets. They visit every pin for writes and read-back, and they use walking-one pad patterns to exercise the synchronizer latency and the interrupt routing.

// File: rtl/pinbank_pkg.sv
// Shared constants for the per-pin GPIO bank: bus widths, the grouped
// sparse register map, control-bit positions and interrupt routing.
// Assumes groups do not overlap and are listed in ascending address order.
package pinbank_pkg;
    localparam int unsigned ADDR_W   = 9;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned STRIDE   = 4;
    localparam int unsigned N_GROUPS = 5;
    localparam int unsigned GRP_BASE [N_GROUPS] = '{32'h50, 32'h88, 32'h140, 32'h188, 32'h1C0};
    localparam int unsigned GRP_CNT  [N_GROUPS] = '{4, 16, 6, 2, 4};

    // Control-bit positions inside a pin register
    localparam int unsigned BIT_IN  = 0;
    localparam int unsigned BIT_OUT = 4;
    localparam int unsigned BIT_OEN = 5;

    // Interrupt routing: one group forwarded to consecutive parent lines
    localparam int unsigned IRQ_GRP        = 4;
    localparam int unsigned IRQ_FIRST_LINE = 28;
    localparam int unsigned N_IRQ          = 32;

    // Index of the first pin of group g (sum of earlier group sizes)
    function automatic int unsigned grp_first(input int unsigned g);
        int unsigned s;
        s = 0;
        for (int unsigned i = 0; i < N_GROUPS; i++)
            if (i < g) s += GRP_CNT[i];
        return s;
    endfunction

    localparam int unsigned N_PINS = grp_first(N_GROUPS);
    localparam int unsigned PIN_W  = (N_PINS > 1) ? $clog2(N_PINS) : 1;
endpackage

// File: rtl/pinbank_decode.sv
// Address decoder: maps a byte offset onto a flat pin index.
// Assumes the group table in pinbank_pkg; misaligned or gap offsets miss.
module pinbank_decode
    import pinbank_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [PIN_W-1:0]  pin
);
    logic [31:0] a_ext;
    assign a_ext = {{(32-ADDR_W){1'b0}}, addr};

    // Compare the offset against every group window in parallel
    always_comb begin
        hit = 1'b0;
        pin = '0;
        for (int unsigned g = 0; g < N_GROUPS; g++) begin
            if ((a_ext % STRIDE) == 0 &&
                a_ext >= GRP_BASE[g] &&
                a_ext <  GRP_BASE[g] + STRIDE * GRP_CNT[g]) begin
                hit = 1'b1;
                pin = PIN_W'(grp_first(g) + (a_ext - GRP_BASE[g]) / STRIDE);
            end
        end
    end
endmodule

// File: rtl/pinbank_sync.sv
// Multi-stage flop synchronizer for a vector of asynchronous pad levels.
// Assumes each bit is independent; no bus coherency is provided.
module pinbank_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift the pad level one stage further on each edge
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= (s == 0) ? d : chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pinbank_pin.sv
// Control state of one pad: held output value and active-low enable.
// Assumes wr_en is already qualified by address decode.
module pinbank_pin (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic out_d,
    input  logic oen_d,
    output logic out_q,
    output logic oen_q
);
    // Load both control bits on a decoded write; reset to input, low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b0;
            oen_q <= 1'b1;
        end else if (wr_en) begin
            out_q <= out_d;
            oen_q <= oen_d;
        end
    end
endmodule

// File: rtl/pinbank_gpio.sv
// Per-pin GPIO bank top: byte bus with single-cycle writes and one-cycle
// registered reads, per-pin control registers on a sparse grouped map,
// synchronized pad inputs, and level forwarding of one group to fixed
// parent interrupt lines. Assumes reads and writes are not issued together.
module pinbank_gpio
    import pinbank_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_oe_n,
    output logic [N_IRQ-1:0]  parent_irq
);
    localparam int unsigned IRQ_PIN0 = grp_first(IRQ_GRP);
    localparam int unsigned IRQ_N    = GRP_CNT[IRQ_GRP];

    logic              dec_hit;
    logic [PIN_W-1:0]  dec_pin;
    logic [N_PINS-1:0] in_sync;
    logic [DATA_W-1:0] rd_word;

    pinbank_decode u_dec (
        .addr (bus_addr),
        .hit  (dec_hit),
        .pin  (dec_pin)
    );

    pinbank_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (in_sync)
    );

    genvar p;
    generate
        for (p = 0; p < N_PINS; p++) begin : g_pin
            pinbank_pin u_pin (
                .clk   (clk),
                .rst_n (rst_n),
                .wr_en (bus_wr && dec_hit && (dec_pin == PIN_W'(p))),
                .out_d (bus_wdata[BIT_OUT]),
                .oen_d (bus_wdata[BIT_OEN]),
                .out_q (pad_out[p]),
                .oen_q (pad_oe_n[p])
            );
        end
    endgenerate

    // Assemble the addressed pin's register image; unused bits stay zero
    always_comb begin
        rd_word          = '0;
        rd_word[BIT_IN]  = in_sync[dec_pin];
        rd_word[BIT_OUT] = pad_out[dec_pin];
        rd_word[BIT_OEN] = pad_oe_n[dec_pin];
    end

    // Register read data for one cycle; zero when idle or unmapped
    always_ff @(posedge clk) begin
        if (!rst_n)                  bus_rdata <= '0;
        else if (bus_rd && dec_hit)  bus_rdata <= rd_word;
        else                         bus_rdata <= '0;
    end

    // Route the interrupt group's synchronized levels to the parent lines
    always_comb begin
        parent_irq = '0;
        for (int unsigned k = 0; k < IRQ_N; k++)
            parent_irq[IRQ_FIRST_LINE + k] = in_sync[IRQ_PIN0 + k];
    end
endmodule

// File: rtl/pinbank_gpio_chk.sv
// Property checker for pinbank_gpio, attached by bind. Assumes bus_rd and
// bus_wr are exclusive and pad_in changes away from the active edge.
module pinbank_gpio_chk
    import pinbank_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [N_PINS-1:0] pad_in,
    input logic [N_PINS-1:0] pad_out,
    input logic [N_PINS-1:0] pad_oe_n,
    input logic [N_IRQ-1:0]  parent_irq
);
    localparam int unsigned IRQ_PIN0 = grp_first(IRQ_GRP);
    localparam logic [DATA_W-1:0] USED =
        DATA_W'((1 << BIT_IN) | (1 << BIT_OUT) | (1 << BIT_OEN));

    logic [1:0] since;
    logic       mapped;
    logic [3:0] irq_hi;
    logic [3:0] pad_hi;

    // Count edges since reset release, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)          since <= '0;
        else if (since != 3) since <= since + 2'd1;
    end

    // Independent membership test of the current offset
    always_comb begin
        mapped = 1'b0;
        for (int unsigned g = 0; g < N_GROUPS; g++)
            for (int unsigned k = 0; k < GRP_CNT[g]; k++)
                if ({{(32-ADDR_W){1'b0}}, bus_addr} == GRP_BASE[g] + STRIDE * k)
                    mapped = 1'b1;
    end

    assign irq_hi = parent_irq[IRQ_FIRST_LINE +: 4];
    assign pad_hi = pad_in[IRQ_PIN0 +: 4];

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (pad_oe_n == '1 && pad_out == '0 && parent_irq == '0 && bus_rdata == '0));

    a_r3_unused_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~USED) == '0);

    a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> bus_rdata == '0);

    a_r4_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since >= 2) |-> irq_hi == $past(pad_hi, 2));

    a_r6_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !mapped) |=> bus_rdata == '0);

    a_r6_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !mapped) |=> ($stable(pad_out) && $stable(pad_oe_n)));

    a_r7_one_pin_out: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> ($countones(pad_out ^ $past(pad_out)) <= 1 &&
                    $countones(pad_oe_n ^ $past(pad_oe_n)) <= 1));

    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(pad_out) && $stable(pad_oe_n)));

    a_r8_low_lines_zero: assert property (@(posedge clk) disable iff (!rst_n)
        parent_irq[IRQ_FIRST_LINE-1:0] == '0);
endmodule

bind pinbank_gpio pinbank_gpio_chk u_chk (.*);

// File: tb/tb_pinbank_gpio.sv
// Self-checking bench for pinbank_gpio: address sweeps, per-pin writes,
// synchronizer latency, interrupt routing and restore after reset.
module tb_pinbank_gpio;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe_n;
    logic [31:0] parent_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] m_out, m_oen;
    logic [7:0]  saved [32];

    always #10 clk = ~clk;

    pinbank_gpio dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe_n(pad_oe_n),
        .parent_irq(parent_irq)
    );

    // Map specification: group bases and sizes, pins in ascending order
    function automatic int addr_to_pin(input int a);
        int bases [5] = '{'h50, 'h88, 'h140, 'h188, 'h1C0};
        int cnts  [5] = '{4, 16, 6, 2, 4};
        int first = 0;
        for (int g = 0; g < 5; g++) begin
            if (a >= bases[g] && a < bases[g] + 4*cnts[g] && (a % 4) == 0)
                return first + (a - bases[g]) / 4;
            first += cnts[g];
        end
        return -1;
    endfunction

    function automatic int pin_to_addr(input int p);
        for (int a = 0; a < 512; a++)
            if (addr_to_pin(a) == p) return a;
        return -1;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = 9'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = 9'(a); bus_rd = 1'b1;
        @(negedge clk);
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        // R1: state while reset is held
        chk("R1 oe_n", pad_oe_n, 32'hFFFF_FFFF);
        chk("R1 out", pad_out, 32'h0);
        chk("R1 irq", parent_irq, 32'h0);
        chk("R1 rdata", {24'h0, bus_rdata}, 32'h0);
        rst_n = 1'b1;
        m_out = '0;
        m_oen = '1;
    endtask

    function automatic logic [7:0] exp_reg(input int p);
        return {2'b00, m_oen[p], m_out[p], 3'b000, pad_in[p]};
    endfunction

    initial begin
        logic [7:0] d;
        logic [31:0] prev_irq;
        logic [31:0] keep_out, keep_oen;
        do_reset();

        // R5 R6 R3: read sweep of every byte offset with pads low
        for (int a = 0; a < 512; a++) begin
            rd(a, d);
            if (addr_to_pin(a) >= 0) chk("R5 mapped read", {24'h0, d}, 32'h20);
            else                     chk("R6 unmapped read", {24'h0, d}, 32'h0);
        end

        // R2 R7 R9: write every pin with a varying pattern, check all pads
        for (int p = 0; p < 32; p++) begin
            logic [7:0] v;
            v = 8'((p * 37 + 5) & 8'hFF);
            wr(pin_to_addr(p), v);
            m_out[p] = v[4];
            m_oen[p] = v[5];
            chk("R2 R7 pad_out", pad_out, m_out);
            chk("R2 R7 pad_oe_n", pad_oe_n, m_oen);
        end
        // R3 R9: read back every pin, ignored bits must be zero
        for (int p = 0; p < 32; p++) begin
            rd(pin_to_addr(p), d);
            chk("R3 R9 readback", {24'h0, d}, {24'h0, exp_reg(p)});
        end

        // R6: writes to every unmapped offset change nothing
        for (int a = 0; a < 512; a++) begin
            if (addr_to_pin(a) < 0) begin
                wr(a, (a % 2 == 0) ? 8'h10 : 8'hEF);
                if (pad_out !== m_out || pad_oe_n !== m_oen)
                    chk("R6 unmapped write", {pad_out ^ m_out} | {pad_oe_n ^ m_oen}, 32'h0);
            end
        end
        chk("R6 unmapped write final out", pad_out, m_out);
        chk("R6 unmapped write final oe", pad_oe_n, m_oen);

        // R4 R8: walking-one pad patterns, two-edge latency on parent lines
        for (int i = 0; i <= 32; i++) begin
            logic [31:0] pat;
            pat = (i == 32) ? 32'hA5C3_5A3C : (32'h1 << i);
            prev_irq = {pad_in[31:28], 28'h0};
            @(negedge clk);
            pad_in = pat;
            @(negedge clk);
            chk("R4 first edge", parent_irq, prev_irq);
            @(negedge clk);
            chk("R8 R4 routed", parent_irq, {pat[31:28], 28'h0});
        end
        // R3 R4: bit 0 reports the synchronized level of each pin
        for (int p = 0; p < 32; p++) begin
            rd(pin_to_addr(p), d);
            chk("R3 R4 input bit", {24'h0, d}, {24'h0, exp_reg(p)});
        end

        // R9: save out/oe bits, reset, write back, compare pads
        keep_out = m_out;
        keep_oen = m_oen;
        for (int p = 0; p < 32; p++) begin
            rd(pin_to_addr(p), d);
            saved[p] = d;
        end
        do_reset();
        for (int p = 0; p < 32; p++) begin
            wr(pin_to_addr(p), saved[p] & 8'h30);
            m_out[p] = saved[p][4];
            m_oen[p] = saved[p][5];
        end
        chk("R9 restore out", pad_out, keep_out);
        chk("R9 restore oe", pad_oe_n, keep_oen);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog got=timeout exp=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule